// File: doc/BRIEF.md
# USB Device Global Control and Interrupt Registers

This block holds the device-wide control and interrupt status of a USB device controller. A CPU reaches it over a simple byte-wide bus with a two-bit address, a write strobe and write data. Read data comes straight back from a combinational read path. The control register carries two bits. One is a remote wake-up request: software sets it, and it stays set until the line logic reports that the upstream resume has finished. The other is a detach bit, which holds the device off the bus. It comes out of reset set, so the device starts detached.

The flag register collects seven device-level events: suspend, micro-frame start, frame start, end of bus reset, wake-up activity, end of host resume, and upstream resume. A flag is set only by a one-cycle event pulse from the line logic, and it is cleared only by software. A separate enable register masks each flag onto a single level interrupt. The remote wake-up request is tracked by a two-state machine. State `WK_IDLE` moves to `WK_RESUMING` on a software write of 1 to the request bit (transition "request"). It returns to `WK_IDLE` on the end-of-resume pulse (transition "complete"). In every other case it holds its state. While the machine is in `WK_RESUMING`, line activity seen as a wake event is the device's own signalling, so it is not recorded.

Top module: `usbg_regs`

## Requirements
- R1: Address 0 is the control register: bit 1 is the remote wake-up request and bit 0 is the detach bit. Bits 7 to 2 read 0.
- R2: After reset, address 0 reads 0x01, addresses 1 and 2 read 0x00, wake_req is 0, detach is 1 and irq is 0.
- R3: A write of 1 to bit 1 at address 0 sets wake_req from the next cycle. A write of 0 to that bit has no effect. A resume_done pulse while the request is set clears it on the next cycle.
- R4: A write to address 0 sets the detach output to written bit 0 from the next cycle.
- R5: Address 1 is the flag register: bit 6 upstream resume, bit 5 end of resume, bit 4 wake-up, bit 3 end of reset, bit 2 frame start, bit 1 micro-frame start, bit 0 suspend. Bit 7 reads 0.
- R6: evt_pulse[i] (i = 0..5) sets flag bit i on the next cycle. A write to address 1 clears each flag whose written bit is 0 and leaves each flag whose written bit is 1. No write sets a flag.
- R7: Address 2 is the enable register: bits 6 to 0 are read/write, use the same positions as the flags, and reset to 0. Bit 7 reads 0 and ignores writes.
- R8: irq is high exactly when some flag bit and its enable bit are both 1. It stays high until those flags or enables are cleared.
- R9: When an event pulse and a software clear reach the same flag in the same cycle, the flag ends up set.
- R10: A resume_done pulse sets flag bit 6 on the next cycle.
- R11: evt_pulse[4] is ignored while wake_req is 1.
- R12: Address 3 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| evt_pulse | input | 6 | Event pulses for flag bits 5..0 |
| resume_done | input | 1 | End of upstream resume pulse |
| wake_req | output | 1 | Remote wake-up request held |
| detach | output | 1 | Device held detached |
| irq | output | 1 | Level interrupt |

## Verification
Every register update, whether from a write, an event pulse or resume_done, takes effect one clock edge after the cycle that carries the stimulus. bus_rdata and irq follow the registers with no further delay, so a result is due in the first cycle after its stimulus edge. The bench holds its inputs across a full cycle. It compares all outputs, and the read data for the current address, with its reference model at the falling edge, after the model has taken the same rising edge. Directed reads are also taken at half-cycle points, so no check is made on the edge where a value is changing.

// File: rtl/usbg_pkg.sv
package usbg_pkg;
    parameter int unsigned DATA_W   = 8;
    parameter int unsigned ADDR_W   = 2;
    parameter int unsigned NUM_FLAG = 7;
    parameter int unsigned NUM_EVT  = 6;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] A_ENAB = 2'd2;

    localparam int unsigned B_DETACH = 0;
    localparam int unsigned B_WAKE   = 1;
    localparam int unsigned F_WAKEUP = 4;
    localparam int unsigned F_UPRES  = 6;

    typedef enum logic [0:0] {
        WK_IDLE     = 1'b0,
        WK_RESUMING = 1'b1
    } wk_state_e;
endpackage

// File: rtl/usbg_wake_fsm.sv
module usbg_wake_fsm
    import usbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic hw_done,
    output logic wake_req
);
    wk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_IDLE:     if (sw_set)  state_d = WK_RESUMING;
            WK_RESUMING: if (hw_done) state_d = WK_IDLE;
            default:     state_d = WK_IDLE;
        endcase
    end

    always_comb begin
        wake_req = (state_q == WK_RESUMING);
    end

    p_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_req && sw_set) |=> wake_req);
    p_hw_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && hw_done) |=> !wake_req);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !hw_done) |=> wake_req);
endmodule

// File: rtl/usbg_flag_bank.sv
module usbg_flag_bank #(
    parameter int unsigned NF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_vec,
    input  logic          sw_wr,
    input  logic [NF-1:0] sw_keep,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_vec[i]) bit_q <= 1'b1;
            else if (sw_wr)      bit_q <= bit_q & sw_keep[i];
        end
        assign flags[i] = bit_q;
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
    p_no_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0) |=> ((flags & ~$past(flags)) == '0));
    p_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && !sw_wr) |=> $stable(flags));
endmodule

// File: rtl/usbg_rw_reg.sv
module usbg_rw_reg #(
    parameter int unsigned W = 7,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= d;
    end

    p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));
endmodule

// File: rtl/usbg_regs.sv
module usbg_regs
    import usbg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_EVT-1:0]   evt_pulse,
    input  logic                 resume_done,
    output logic                 wake_req,
    output logic                 detach,
    output logic                 irq
);
    localparam int unsigned PAD_F = DATA_W - NUM_FLAG;
    localparam int unsigned PAD_C = DATA_W - 2;

    logic                wr_ctrl, wr_flag, wr_enab;
    logic [NUM_FLAG-1:0] set_vec, flags, enab;
    logic [0:0]          det_q;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_flag = bus_wr && (bus_addr == A_FLAG);
        wr_enab = bus_wr && (bus_addr == A_ENAB);
    end

    usbg_wake_fsm u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_set   (wr_ctrl && bus_wdata[B_WAKE]),
        .hw_done  (resume_done),
        .wake_req (wake_req)
    );

    usbg_rw_reg #(.W(1), .RST(1'b1)) u_det (
        .clk (clk),
        .rst_n (rst_n),
        .we  (wr_ctrl),
        .d   (bus_wdata[B_DETACH]),
        .q   (det_q)
    );
    assign detach = det_q[0];

    always_comb begin
        set_vec = {1'b0, evt_pulse};
        set_vec[F_WAKEUP] = evt_pulse[F_WAKEUP] && !wake_req;
        set_vec[F_UPRES]  = resume_done;
    end

    usbg_flag_bank #(.NF(NUM_FLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .sw_wr   (wr_flag),
        .sw_keep (bus_wdata[NUM_FLAG-1:0]),
        .flags   (flags)
    );

    usbg_rw_reg #(.W(NUM_FLAG), .RST('0)) u_enab (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_enab),
        .d     (bus_wdata[NUM_FLAG-1:0]),
        .q     (enab)
    );

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {{PAD_C{1'b0}}, wake_req, detach};
            A_FLAG:  bus_rdata = {{PAD_F{1'b0}}, flags};
            A_ENAB:  bus_rdata = {{PAD_F{1'b0}}, enab};
            default: bus_rdata = '0;
        endcase
        irq = |(flags & enab);
    end

    p_rsv_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> (bus_rdata[DATA_W-1:2] == '0));
    p_detach_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (detach == $past(bus_wdata[B_DETACH])));
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq);
    p_upres_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resume_done |=> flags[F_UPRES]);
    p_wake_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !flags[F_WAKEUP]) |=> !flags[F_WAKEUP]);
endmodule

// File: tb/tb_usbg_regs.sv
module tb_usbg_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] evt_pulse = '0;
    logic       resume_done = 1'b0;
    logic       wake_req, detach, irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // reference model state
    bit       m_wk;
    bit       m_det;
    bit [6:0] m_fl;
    bit [6:0] m_en;

    always #2.5 clk = ~clk;

    usbg_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .resume_done(resume_done), .wake_req(wake_req), .detach(detach), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        bit [6:0] ev;
        bit [6:0] nf;
        if (!rst_n) begin
            m_wk = 0; m_det = 1; m_fl = '0; m_en = '0;
        end else begin
            nf = m_fl;
            if (bus_wr && bus_addr == 2'd1) nf = nf & bus_wdata[6:0];
            ev = {resume_done, evt_pulse[5], evt_pulse[4] & ~m_wk, evt_pulse[3:0]};
            nf = nf | ev;
            if (bus_wr && bus_addr == 2'd0) m_det = bus_wdata[0];
            if (bus_wr && bus_addr == 2'd2) m_en = bus_wdata[6:0];
            if (m_wk && resume_done) m_wk = 0;
            else if (!m_wk && bus_wr && bus_addr == 2'd0 && bus_wdata[1]) m_wk = 1;
            m_fl = nf;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    function automatic bit [7:0] model_rd(input bit [1:0] a);
        case (a)
            2'd0: return {6'b0, m_wk, m_det};
            2'd1: return {1'b0, m_fl};
            2'd2: return {1'b0, m_en};
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare_all();
        string t;
        case (bus_addr)
            2'd0: t = "R1";
            2'd1: t = "R5";
            2'd2: t = "R7";
            default: t = "R12";
        endcase
        chk(t, bus_rdata, model_rd(bus_addr));
        chk("R3", wake_req, m_wk);
        chk("R4", detach, m_det);
        chk("R8", irq, |(m_fl & m_en));
    endtask

    task automatic step(input bit [1:0] a, input bit w, input bit [7:0] d,
                        input bit [5:0] e, input bit rd);
        bus_addr = a; bus_wr = w; bus_wdata = d; evt_pulse = e; resume_done = rd;
        @(negedge clk);
        cyc++;
        compare_all();
    endtask

    task automatic peek(input bit [1:0] a, input string tag, input bit [7:0] exp);
        bus_addr = a; bus_wr = 0; evt_pulse = '0; resume_done = 0;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        peek(2'd0, "R2", 8'h01);
        peek(2'd1, "R2", 8'h00);
        peek(2'd2, "R2", 8'h00);
        chk("R2", wake_req, 0);
        chk("R2", detach, 1);
        chk("R2", irq, 0);
        rst_n = 1'b1;
        step(2'd0, 0, 8'h00, '0, 0);

        // R7: enable write, reserved bit 7 ignored
        step(2'd2, 1, 8'hFF, '0, 0);
        peek(2'd2, "R7", 8'h7F);
        // R9: set and clear in the same cycle on frame start flag
        step(2'd1, 1, 8'h00, 6'b000100, 0);
        peek(2'd1, "R9", 8'h04);
        chk("R8", irq, 1);
        // R3/R4: request wake-up, attach
        step(2'd0, 1, 8'h02, '0, 0);
        peek(2'd0, "R3", 8'h02);
        chk("R4", detach, 0);
        // R3: write 0 to the wake bit does nothing
        step(2'd0, 1, 8'h00, '0, 0);
        chk("R3", wake_req, 1);
        // R11: wake event during own resume ignored
        step(2'd0, 0, 8'h00, 6'b010000, 0);
        peek(2'd1, "R11", 8'h04);
        // R10/R3: resume done
        step(2'd0, 0, 8'h00, '0, 1);
        chk("R3", wake_req, 0);
        peek(2'd1, "R10", 8'h44);
        // R6: writing ones does not set, keeps
        step(2'd1, 1, 8'hFF, '0, 0);
        peek(2'd1, "R6", 8'h44);
        // R6/R8: clear all flags
        step(2'd1, 1, 8'h00, '0, 0);
        peek(2'd1, "R6", 8'h00);
        chk("R8", irq, 0);
        // R11: wake event counts when no request
        step(2'd0, 0, 8'h00, 6'b010000, 0);
        peek(2'd1, "R11", 8'h10);
        // R12: address 3 write ignored
        step(2'd3, 1, 8'hFF, '0, 0);
        peek(2'd3, "R12", 8'h00);
        peek(2'd0, "R12", 8'h00);
        peek(2'd2, "R12", 8'h7F);
        // R4: detach again
        step(2'd0, 1, 8'h01, '0, 0);
        chk("R4", detach, 1);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            bit [5:0] e;
            bit [2:0] r;
            e = '0;
            for (int b = 0; b < 6; b++) if ($urandom_range(0, 15) == 0) e[b] = 1'b1;
            r = 3'($urandom_range(0, 7));
            step(2'($urandom_range(0, 3)), (r < 3), 8'($urandom_range(0, 255)), e,
                 ($urandom_range(0, 19) == 0));
        end
        finish_run();
    end
endmodule